// File: doc/BRIEF.md
# DDR2 Posted Column Command Scheduler

This block models, on the memory side, when a DDR2-style SDRAM moves data for its column commands. Activate, read and write commands arrive one per clock on a single-data-rate command port. Each read or write is held internally for a programmable additive latency (AL). The block then raises a read-data window at the read latency RL = AL + CL, or a write-data window at the write latency WL = RL - 1. A window lasts BL/2 clocks, because data moves on both clock edges. A beat index names the beat carried on the rising edge of each clock in the window. The beat on the falling edge of that clock is the index plus one.

The block also checks column commands for legality. A command is rejected if it goes to a bank that was never activated, if it comes too soon after the previous accepted column command, or if it interrupts an earlier burst in a way that is not allowed. A rejected command is dropped and raises a one-clock error pulse. With burst length 8, a read may cut off an earlier read, and a write an earlier write, exactly at the four-beat boundary.

The settings AL (0 to 5), CL (3 to 6) and the burst-length select are captured only while no command is waiting and no burst is running. Values outside these ranges are clamped. The command port has no ready signal and never applies back-pressure: every command presented with `cmd_valid` is either accepted or dropped with an error in that same clock. The data windows are timing strobes that cannot be stalled, so they carry no ready either.

Top module: `ddr2_col_sched`

## Requirements
- R1: After reset, `rd_valid`, `wr_valid` and `err_pulse` are low and every bank is inactive.
- R2: Command codes on `cmd_type` are 0 no-op, 1 activate, 2 read and 3 write. An activate marks `cmd_bank` active. A read or write to an inactive bank gives `err_pulse` high in the clock after the command and produces no data window.
- R3: If a read is presented in clock 0, `rd_valid` is first high in clock RL = AL + CL.
- R4: If a write is presented in clock 0, `wr_valid` is first high in clock WL = AL + CL - 1.
- R5: A lone burst keeps its valid high for BL/2 clocks, with BL = 8 when `cfg_bl8` = 1 and BL = 4 otherwise. `beat_idx` reads 0, 2, 4, 6 in successive clocks of the window.
- R6: A column command whose gap to the previous accepted column command is less than 2 clocks is dropped and raises `err_pulse` in the next clock.
- R7: With BL = 4, two same-type commands 2 clocks apart give one seamless 4-clock window with beats 0, 2, 0, 2.
- R8: With BL = 8, a same-type command 2 clocks after the previous one is legal. It ends the first burst after beat 3, and its own beats 0 to 6 follow with no gap (6 valid clocks in total).
- R9: With BL = 8, a same-type command exactly 3 clocks after the previous one is dropped with `err_pulse`.
- R10: A column command of the other type within BL/2 clocks of the previous accepted one is dropped with `err_pulse`. At a larger gap both windows appear, and they never overlap.
- R11: The AL, CL and burst-length settings are captured only while the block is idle. Changes made while a burst is pending or running do not affect that traffic.
- R12: A read or write may follow its activate in the very next clock, and its window then appears AL + CL (read) or AL + CL - 1 (write) clocks after the column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this clock |
| cmd_type | input | 2 | 0 no-op, 1 activate, 2 read, 3 write |
| cmd_bank | input | BANK_W (3) | Target bank |
| cfg_al | input | 3 | Additive latency, 0 to 5 |
| cfg_cl | input | 3 | CAS latency, 3 to 6 |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| rd_valid | output | 1 | Read data window |
| wr_valid | output | 1 | Write data window |
| beat_idx | output | 3 | Beat index on the rising edge of the current window clock |
| err_pulse | output | 1 | One-clock pulse for a dropped column command |

## Verification
The bench sweeps every AL/CL pair at both burst lengths, for reads and for writes. A latency adder that is off by one, or a write latency that equals the read latency, moves a window edge and is caught. The bench also probes the exact gaps where legality changes: 1 versus 2 for tCCD, 2, 3 and 4 for same-type BL8 interrupts, and BL/2 versus BL/2 + 1 across types. A design that restarts the beat count in the wrong place, or accepts an off-boundary interrupt, shows the wrong window length or beat sequence. A settings change injected mid-burst catches a design that captures its settings while busy.

// File: rtl/ddr2cs_pkg.sv
package ddr2cs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  localparam int AL_MAX  = 5;
  localparam int CL_MIN  = 3;
  localparam int CL_MAX  = 6;
  localparam int LAT_MAX = AL_MAX + CL_MAX;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);
  localparam int GAP_W   = 3;

  function automatic logic [2:0] clamp_al(input logic [2:0] a);
    return (a > 3'(AL_MAX)) ? 3'(AL_MAX) : a;
  endfunction

  function automatic logic [2:0] clamp_cl(input logic [2:0] c);
    if (c < 3'(CL_MIN)) return 3'(CL_MIN);
    if (c > 3'(CL_MAX)) return 3'(CL_MAX);
    return c;
  endfunction
endpackage

// File: rtl/ddr2cs_bank_track.sv
module ddr2cs_bank_track #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic [BANK_W-1:0] bank,
  output logic              bank_open
);
  logic [NUM_BANKS-1:0] open_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q[b] <= 1'b0;
      else if (act_req && bank == BANK_W'(b)) open_q[b] <= 1'b1;
    end
  end

  assign bank_open = open_q[bank];
endmodule

// File: rtl/ddr2cs_col_check.sv
module ddr2cs_col_check
  import ddr2cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic col_req,
  input  logic is_wr,
  input  logic bank_open,
  input  logic bl8,
  output logic accept,
  output logic bad
);
  logic [GAP_W-1:0] gap_q;
  logic             last_wr_q;
  logic [GAP_W-1:0] half;
  logic             ccd_bad, intr_bad;

  assign half     = bl8 ? GAP_W'(4) : GAP_W'(2);
  assign ccd_bad  = gap_q < GAP_W'(2);
  assign intr_bad = (is_wr == last_wr_q) ? (bl8 && gap_q == GAP_W'(3))
                                         : (gap_q <= half);
  assign bad      = col_req && (!bank_open || ccd_bad || intr_bad);
  assign accept   = col_req && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '1;
      last_wr_q <= 1'b0;
    end else if (accept) begin
      gap_q     <= GAP_W'(1);
      last_wr_q <= is_wr;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> gap_q == GAP_W'(1)); // R6
endmodule

// File: rtl/ddr2cs_lat_pipe.sv
module ddr2cs_lat_pipe
  import ddr2cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LAT_W-1:0] lat,
  input  logic             bl8,
  output logic             valid,
  output logic [2:0]       beat,
  output logic             busy
);
  logic [LAT_MAX-1:0] sreg_q, sreg_d;
  logic [1:0]         cnt_q, last;
  logic               run_q, start;

  always_comb begin
    sreg_d = sreg_q >> 1;
    if (push) sreg_d[lat - LAT_W'(1)] = 1'b1;
  end

  assign start = sreg_q[0];
  assign last  = bl8 ? 2'd3 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      run_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      sreg_q <= sreg_d;
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= 2'd1;
      end else if (run_q) begin
        if (cnt_q == last) run_q <= 1'b0;
        else cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign valid = start || run_q;
  assign beat  = start ? 3'd0 : {cnt_q, 1'b0};
  assign busy  = (|sreg_q) || run_q;

  AST_INTERRUPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_q) |-> (bl8 && cnt_q == 2'd2)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != 2'd0 && cnt_q <= last)); // R5
endmodule

// File: rtl/ddr2_col_sched.sv
module ddr2_col_sched
  import ddr2cs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [2:0]        cfg_al,
  input  logic [2:0]        cfg_cl,
  input  logic              cfg_bl8,
  output logic              rd_valid,
  output logic              wr_valid,
  output logic [2:0]        beat_idx,
  output logic              err_pulse
);
  cmd_e             ctype;
  logic             act_req, col_req, is_wr, bank_open, accept, bad;
  logic [2:0]       al_q, cl_q;
  logic             bl8_q, idle, err_q;
  logic [LAT_W-1:0] rl, wl;
  logic [1:0]       v, bsy;
  logic [2:0]       bt [2];

  assign ctype   = cmd_e'(cmd_type);
  assign act_req = cmd_valid && ctype == CMD_ACT;
  assign col_req = cmd_valid && (ctype == CMD_RD || ctype == CMD_WR);
  assign is_wr   = ctype == CMD_WR;

  ddr2cs_bank_track #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .bank(cmd_bank),
    .bank_open(bank_open));

  ddr2cs_col_check u_check (
    .clk(clk), .rst_n(rst_n), .col_req(col_req), .is_wr(is_wr),
    .bank_open(bank_open), .bl8(bl8_q), .accept(accept), .bad(bad));

  assign idle = ~|bsy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q  <= 3'd0;
      cl_q  <= 3'(CL_MIN);
      bl8_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad;
      if (idle) begin
        al_q  <= clamp_al(cfg_al);
        cl_q  <= clamp_cl(cfg_cl);
        bl8_q <= cfg_bl8;
      end
    end
  end

  assign rl = LAT_W'(al_q) + LAT_W'(cl_q);
  assign wl = rl - LAT_W'(1);

  for (genvar g = 0; g < 2; g++) begin : g_dir
    ddr2cs_lat_pipe u_pipe (
      .clk(clk), .rst_n(rst_n),
      .push(accept && (is_wr == (g == 1))),
      .lat((g == 1) ? wl : rl),
      .bl8(bl8_q),
      .valid(v[g]), .beat(bt[g]), .busy(bsy[g]));
  end

  assign rd_valid  = v[0];
  assign wr_valid  = v[1];
  assign beat_idx  = v[0] ? bt[0] : bt[1];
  assign err_pulse = err_q;

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R10
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(al_q) && $stable(cl_q) && $stable(bl8_q))); // R11
  AST_DROP_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (col_req && !bank_open) |=> err_pulse); // R2
endmodule

// File: tb/tb_ddr2_col_sched.sv
`timescale 1ns/1ps
module tb_ddr2_col_sched;
  import ddr2cs_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic [2:0] cfg_al = 3'd0, cfg_cl = 3'd3;
  logic cfg_bl8 = 1'b0;
  logic rd_valid, wr_valid, err_pulse;
  logic [2:0] beat_idx;

  int checks = 0, errors = 0;
  logic [39:0] rd_a, wr_a, er_a;
  logic [2:0]  bt_a [40];

  always #10 clk = ~clk;

  ddr2_col_sched dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bank(cmd_bank), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .rd_valid(rd_valid), .wr_valid(wr_valid), .beat_idx(beat_idx),
    .err_pulse(err_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_hi(input logic [39:0] v);
    for (int i = 0; i < 40; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic settle();
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // Two commands: first at clock 0, second at clock gap; optional AL change at clock chg_c
  task automatic run2(input logic [1:0] t0, input logic [2:0] b0,
                      input logic [1:0] t1, input logic [2:0] b1,
                      input int gap, input int chg_c, input logic [2:0] chg_al);
    rd_a = '0; wr_a = '0; er_a = '0;
    for (int c = 0; c < 39; c++) begin
      cmd_valid = 1'b0;
      if (c == 0) begin cmd_valid = 1'b1; cmd_type = t0; cmd_bank = b0; end
      else if (c == gap) begin cmd_valid = 1'b1; cmd_type = t1; cmd_bank = b1; end
      if (c == chg_c) cfg_al = chg_al;
      @(negedge clk);
      rd_a[c+1] = rd_valid; wr_a[c+1] = wr_valid; er_a[c+1] = err_pulse;
      bt_a[c+1] = beat_idx;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic set_cfg(input int al, input int cl, input bit b8);
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = b8;
    settle();
  endtask

  task automatic t_reset();
    chk(rd_valid == 0 && wr_valid == 0 && err_pulse == 0, "R1 idle outputs",
        {rd_valid, wr_valid, err_pulse}, 0);
    set_cfg(0, 3, 0);
    run2(CMD_RD, 3'd6, CMD_NOP, 3'd0, 99, -1, 3'd0);
    chk(er_a[1] == 1 && $countones(rd_a) == 0, "R1 R2 bank inactive after reset",
        $countones(rd_a), 0);
  endtask

  task automatic t_sweep();
    for (int b = 0; b < 2; b++)
      for (int al = 0; al <= 5; al++)
        for (int cl = 3; cl <= 6; cl++) begin
          int bw;
          bw = (b == 1) ? 4 : 2;
          set_cfg(al, cl, b[0]);
          run2(CMD_RD, 3'd0, CMD_NOP, 3'd0, 99, -1, 3'd0);
          chk(first_hi(rd_a) == al + cl, "R3 read start", first_hi(rd_a), al + cl);
          chk($countones(rd_a) == bw, "R5 read length", $countones(rd_a), bw);
          chk(int'(bt_a[al+cl+bw-1]) == 2*(bw-1), "R5 last beat",
              bt_a[al+cl+bw-1], 2*(bw-1));
          settle();
          run2(CMD_WR, 3'd0, CMD_NOP, 3'd0, 99, -1, 3'd0);
          chk(first_hi(wr_a) == al + cl - 1, "R4 write start", first_hi(wr_a), al + cl - 1);
          chk($countones(wr_a) == bw && er_a == 0, "R5 write length",
              $countones(wr_a), bw);
        end
  endtask

  task automatic t_spacing();
    set_cfg(0, 3, 0);
    run2(CMD_RD, 3'd0, CMD_RD, 3'd0, 1, -1, 3'd0);
    chk(er_a[2] == 1 && $countones(rd_a) == 2, "R6 tCCD gap 1 dropped",
        $countones(rd_a), 2);
    settle();
    run2(CMD_RD, 3'd0, CMD_RD, 3'd0, 2, -1, 3'd0);
    chk($countones(rd_a) == 4 && first_hi(rd_a) == 3 && er_a == 0, "R7 BL4 seamless",
        $countones(rd_a), 4);
    chk(bt_a[5] == 3'd0 && bt_a[6] == 3'd2, "R7 beats restart", bt_a[5], 0);
    settle();
    set_cfg(0, 3, 1);
    run2(CMD_RD, 3'd0, CMD_RD, 3'd0, 2, -1, 3'd0);
    chk($countones(rd_a) == 6 && er_a == 0, "R8 BL8 interrupt length",
        $countones(rd_a), 6);
    chk(bt_a[4] == 3'd2 && bt_a[5] == 3'd0 && bt_a[8] == 3'd6, "R8 interrupt beats",
        bt_a[5], 0);
    settle();
    run2(CMD_WR, 3'd0, CMD_WR, 3'd0, 2, -1, 3'd0);
    chk($countones(wr_a) == 6 && first_hi(wr_a) == 2, "R8 BL8 write interrupt",
        $countones(wr_a), 6);
    settle();
    run2(CMD_RD, 3'd0, CMD_RD, 3'd0, 3, -1, 3'd0);
    chk(er_a[4] == 1 && $countones(rd_a) == 4, "R9 BL8 gap 3 dropped",
        $countones(rd_a), 4);
    settle();
    run2(CMD_WR, 3'd0, CMD_RD, 3'd0, 4, -1, 3'd0);
    chk(er_a[5] == 1 && $countones(rd_a) == 0, "R10 BL8 WR->RD gap 4 dropped",
        $countones(rd_a), 0);
    settle();
    run2(CMD_WR, 3'd0, CMD_RD, 3'd0, 5, -1, 3'd0);
    chk(er_a == 0 && first_hi(rd_a) == 8 && $countones(wr_a) == 4, "R10 BL8 WR->RD gap 5",
        first_hi(rd_a), 8);
    settle();
    set_cfg(0, 3, 0);
    run2(CMD_RD, 3'd0, CMD_WR, 3'd0, 2, -1, 3'd0);
    chk(er_a[3] == 1 && $countones(wr_a) == 0, "R10 BL4 RD->WR gap 2 dropped",
        $countones(wr_a), 0);
    settle();
    run2(CMD_RD, 3'd0, CMD_WR, 3'd0, 3, -1, 3'd0);
    chk(er_a == 0 && first_hi(wr_a) == 5 && $countones(rd_a) == 2, "R10 BL4 RD->WR gap 3",
        first_hi(wr_a), 5);
    settle();
  endtask

  task automatic t_cfg_busy();
    set_cfg(1, 3, 0);
    run2(CMD_RD, 3'd0, CMD_RD, 3'd0, 3, 2, 3'd4);
    chk(first_hi(rd_a) == 4 && rd_a[7] == 1 && rd_a[9] == 0 && $countones(rd_a) == 4,
        "R11 cfg change ignored while busy", first_hi(rd_a), 4);
    settle();
    run2(CMD_RD, 3'd0, CMD_NOP, 3'd0, 99, -1, 3'd0);
    chk(first_hi(rd_a) == 7, "R11 cfg taken once idle", first_hi(rd_a), 7);
    settle();
  endtask

  task automatic t_posted();
    set_cfg(2, 3, 0);
    run2(CMD_ACT, 3'd2, CMD_RD, 3'd2, 1, -1, 3'd0);
    chk(er_a == 0 && first_hi(rd_a) == 6, "R12 read right after activate",
        first_hi(rd_a), 6);
    settle();
    run2(CMD_ACT, 3'd3, CMD_WR, 3'd3, 1, -1, 3'd0);
    chk(er_a == 0 && first_hi(wr_a) == 5, "R12 write right after activate",
        first_hi(wr_a), 5);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run2(CMD_ACT, 3'd0, CMD_NOP, 3'd0, 99, -1, 3'd0);
    chk(er_a == 0, "R2 activate bank 0", $countones(er_a), 0);
    settle();
    t_sweep();
    t_spacing();
    t_cfg_busy();
    t_posted();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule